// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connection Controller

This controller sits on a plug-in card that joins a live I2C backplane. It receives two supply-good indications and the logic levels of SDA and SCL on both the backplane side and the card side. Its outputs are an open-drain pull-down request for each of the four lines, plus a precharge enable, a connect flag and a rise-time accelerator enable for the analog stage around it.

After reset or insertion, the block stays isolated in lockout until the supplies are good. While in lockout it requests precharge, and bus activity has no effect. Once the supplies are good, it waits for the backplane to finish any transaction it has joined part-way. It accepts either a STOP condition or a long enough idle stretch as the end of that transaction. It also needs both card-side lines to be high before it joins the two buses. From then on it repeats each line in both directions as a wired-AND. For each line it records which side started the low, so that its own mirrored drive cannot hold the line low.

The supply-good inputs are taken as synchronous to the clock. The four line inputs pass through two-flop synchronisers before any logic uses them.

Top module: `hsbus_link`

## Requirements
- R1: During reset and immediately after it, precharge_o is 1, while connect_o, accel_en_o and all four pull-down outputs are 0.
- R2: While pwr_ok_i is 0 the block stays in lockout: precharge_o stays 1, connect_o stays 0, and no pull-down output asserts, whatever the four lines do.
- R3: With NEED_SECOND_SUPPLY=1, lockout is also held while pwr2_ok_i is 0. Once both inputs are 1, precharge_o drops at the next clock edge.
- R4: After lockout, a backplane STOP arms the connection. A STOP is synchronised SDA going from 0 to 1 while synchronised SCL is 1 in both samples. The connection is only made while both synchronised card-side lines are 1.
- R5: Backplane SDA and SCL both reading 1 for IDLE_CYCLES consecutive synchronised samples also arms the connection. Any 0 restarts the count.
- R6: connect_o and accel_en_o assert in the same cycle, and precharge_o deasserts in that cycle.
- R7: While connected, a low on a backplane line asserts the matching card-side pull-down three clock edges after the low appears at the input.
- R8: While connected, a low on a card-side line asserts the matching backplane pull-down with the same latency.
- R9: A mirrored pull-down is released only when the side that started the low reads high. The echo of the block's own drive is ignored for RELEASE_HOLD cycles after release, so a line never latches low. A line stays low while any driver on either side holds it.
- R10: SCL is repeated by the same rules as SDA.
- R11: If a required supply-good input is 0 at a clock edge while connected, connect_o, accel_en_o and all pull-downs are 0 and precharge_o is 1 right after that edge.
- R12: If both sides of a line go low in the same sample, the backplane side is taken as the originator, so only the card-side pull-down asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Primary supply good |
| pwr2_ok_i | input | 1 | Secondary supply good |
| bp_sda_i | input | 1 | Backplane SDA level |
| bp_scl_i | input | 1 | Backplane SCL level |
| cd_sda_i | input | 1 | Card-side SDA level |
| cd_scl_i | input | 1 | Card-side SCL level |
| precharge_o | output | 1 | Precharge enable, high in lockout |
| connect_o | output | 1 | Buses joined |
| accel_en_o | output | 1 | Rise-time accelerator enable |
| bp_sda_pd_o | output | 1 | Pull backplane SDA low |
| bp_scl_pd_o | output | 1 | Pull backplane SCL low |
| cd_sda_pd_o | output | 1 | Pull card SDA low |
| cd_scl_pd_o | output | 1 | Pull card SCL low |

## Verification
Some properties are checked on every cycle by assertions. Connect and accelerator enable always match. Precharge and connect are never high together. No pull-down asserts while the buses are unjoined. For each line, at most one side is ever pulled by the block. A missing supply forces isolation on the following edge.

Other behaviour depends on sequences and on the surrounding bus, so only the bench scenarios can show it. That includes STOP versus idle arming, gating by the card-side lines, the three-edge repeat latency, the originator rule when both sides pull low together, and lines returning high with no latch-up once every driver has released. The bench closes the wired-AND loop itself and compares every output each cycle against its own model.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
  typedef enum logic [1:0] {
    LK_LOCK = 2'd0,
    LK_WAIT = 2'd1,
    LK_LINK = 2'd2
  } lk_state_e;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_BP   = 2'd1,
    SIDE_CD   = 2'd2
  } side_e;
endpackage

// File: rtl/hsbus_sync2.sv
module hsbus_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // lines idle high, so both stages reset to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hsbus_gate.sv
module hsbus_gate
  import hsbus_pkg::*;
#(
  parameter int IDLE_CYCLES        = 1000,
  parameter bit NEED_SECOND_SUPPLY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic pwr2_ok,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic cd_sda,
  input  logic cd_scl,
  output logic link,
  output logic lock
);
  localparam int              CNT_W   = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  lk_state_e        st_q, st_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sda_prev_q, scl_prev_q;
  logic             supply_ok, stop_ev, idle_ev, bp_high, card_high, trig;

  generate
    if (NEED_SECOND_SUPPLY) begin : g_two_rails
      assign supply_ok = pwr_ok & pwr2_ok;
    end else begin : g_one_rail
      assign supply_ok = pwr_ok;
    end
  endgenerate

  assign bp_high   = bp_sda & bp_scl;
  assign card_high = cd_sda & cd_scl;
  assign stop_ev   = bp_scl & scl_prev_q & bp_sda & ~sda_prev_q;
  assign idle_ev   = (cnt_q == CNT_MAX);
  assign trig      = armed_q | stop_ev | idle_ev;

  always_comb begin
    st_d    = st_q;
    armed_d = 1'b0;
    cnt_d   = '0;
    case (st_q)
      LK_LOCK: begin
        if (supply_ok) st_d = LK_WAIT;
      end
      LK_WAIT: begin
        if (!supply_ok) begin
          st_d = LK_LOCK;
        end else if (trig && card_high) begin
          st_d = LK_LINK;
        end else begin
          armed_d = trig;
          if (bp_high) cnt_d = idle_ev ? cnt_q : cnt_q + 1'b1;
        end
      end
      LK_LINK: begin
        if (!supply_ok) st_d = LK_LOCK;
      end
      default: st_d = LK_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= LK_LOCK;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      armed_q    <= armed_d;
      cnt_q      <= cnt_d;
      sda_prev_q <= bp_sda;
      scl_prev_q <= bp_scl;
    end
  end

  assign link = (st_q == LK_LINK);
  assign lock = (st_q == LK_LOCK);
endmodule

// File: rtl/hsbus_mirror.sv
module hsbus_mirror
  import hsbus_pkg::*;
#(
  parameter int RELEASE_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bp_lvl,
  input  logic cd_lvl,
  output logic bp_pd,
  output logic cd_pd
);
  localparam int              HOLD_W   = $clog2(RELEASE_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(RELEASE_HOLD);

  side_e             own_q, own_d;
  side_e             last_q, last_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_on, ign_bp, ign_cd;

  assign hold_on = (hold_q != '0);
  assign ign_cd  = hold_on && (last_q == SIDE_BP);
  assign ign_bp  = hold_on && (last_q == SIDE_CD);

  always_comb begin
    own_d  = own_q;
    last_d = last_q;
    hold_d = hold_on ? hold_q - 1'b1 : '0;
    if (!en) begin
      own_d  = SIDE_NONE;
      hold_d = '0;
    end else begin
      case (own_q)
        SIDE_NONE: begin
          if (!bp_lvl && !ign_bp) begin
            own_d  = SIDE_BP;
            last_d = SIDE_BP;
          end else if (!cd_lvl && !ign_cd) begin
            own_d  = SIDE_CD;
            last_d = SIDE_CD;
          end
        end
        SIDE_BP: begin
          if (bp_lvl) begin
            own_d  = SIDE_NONE;
            hold_d = HOLD_MAX;
          end
        end
        SIDE_CD: begin
          if (cd_lvl) begin
            own_d  = SIDE_NONE;
            hold_d = HOLD_MAX;
          end
        end
        default: own_d = SIDE_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= SIDE_NONE;
      last_q <= SIDE_NONE;
      hold_q <= '0;
    end else begin
      own_q  <= own_d;
      last_q <= last_d;
      hold_q <= hold_d;
    end
  end

  assign cd_pd = (own_q == SIDE_BP);
  assign bp_pd = (own_q == SIDE_CD);
endmodule

// File: rtl/hsbus_link.sv
module hsbus_link #(
  parameter int IDLE_CYCLES        = 1000,
  parameter int RELEASE_HOLD       = 4,
  parameter bit NEED_SECOND_SUPPLY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic pwr2_ok_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  output logic precharge_o,
  output logic connect_o,
  output logic accel_en_o,
  output logic bp_sda_pd_o,
  output logic bp_scl_pd_o,
  output logic cd_sda_pd_o,
  output logic cd_scl_pd_o
);
  localparam int NLINES = 2;

  logic       rst_meta_q, rst_sync_q;
  logic [3:0] raw_lvl, sync_lvl;
  logic       link, lock;
  logic [NLINES-1:0] bp_s, cd_s, bp_pd, cd_pd;

  // reset asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_lvl = {cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};

  hsbus_sync2 #(.W(4)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d_i  (raw_lvl),
    .q_o  (sync_lvl)
  );

  assign bp_s = sync_lvl[1:0];
  assign cd_s = sync_lvl[3:2];

  hsbus_gate #(
    .IDLE_CYCLES       (IDLE_CYCLES),
    .NEED_SECOND_SUPPLY(NEED_SECOND_SUPPLY)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .pwr_ok (pwr_ok_i),
    .pwr2_ok(pwr2_ok_i),
    .bp_sda (bp_s[0]),
    .bp_scl (bp_s[1]),
    .cd_sda (cd_s[0]),
    .cd_scl (cd_s[1]),
    .link   (link),
    .lock   (lock)
  );

  // index 0 is SDA, index 1 is SCL
  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      hsbus_mirror #(.RELEASE_HOLD(RELEASE_HOLD)) u_mirror (
        .clk   (clk),
        .rst_n (rst_sync_q),
        .en    (link),
        .bp_lvl(bp_s[i]),
        .cd_lvl(cd_s[i]),
        .bp_pd (bp_pd[i]),
        .cd_pd (cd_pd[i])
      );
    end
  endgenerate

  assign precharge_o = lock;
  assign connect_o   = link;
  assign accel_en_o  = link;
  assign bp_sda_pd_o = bp_pd[0] & link;
  assign bp_scl_pd_o = bp_pd[1] & link;
  assign cd_sda_pd_o = cd_pd[0] & link;
  assign cd_scl_pd_o = cd_pd[1] & link;
endmodule

// File: rtl/hsbus_link_chk.sv
module hsbus_link_chk #(
  parameter bit NEED_SECOND_SUPPLY = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok_i,
  input logic pwr2_ok_i,
  input logic precharge_o,
  input logic connect_o,
  input logic accel_en_o,
  input logic bp_sda_pd_o,
  input logic bp_scl_pd_o,
  input logic cd_sda_pd_o,
  input logic cd_scl_pd_o
);
  AST_CONN_WITH_ACCEL: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o == accel_en_o); // R6

  AST_PRECHARGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_o |-> !connect_o); // R2

  AST_PD_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_sda_pd_o || bp_scl_pd_o || cd_sda_pd_o || cd_scl_pd_o) |-> connect_o); // R2

  AST_SDA_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_sda_pd_o && cd_sda_pd_o)); // R9

  AST_SCL_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_scl_pd_o && cd_scl_pd_o)); // R10

  AST_DROP_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> (precharge_o && !connect_o)); // R11

  AST_SECOND_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (NEED_SECOND_SUPPLY && !pwr2_ok_i) |=> !connect_o); // R3
endmodule

bind hsbus_link hsbus_link_chk #(.NEED_SECOND_SUPPLY(NEED_SECOND_SUPPLY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_ok_i   (pwr_ok_i),
  .pwr2_ok_i  (pwr2_ok_i),
  .precharge_o(precharge_o),
  .connect_o  (connect_o),
  .accel_en_o (accel_en_o),
  .bp_sda_pd_o(bp_sda_pd_o),
  .bp_scl_pd_o(bp_scl_pd_o),
  .cd_sda_pd_o(cd_sda_pd_o),
  .cd_scl_pd_o(cd_scl_pd_o)
);

// File: tb/hsbus_link_tb_top.sv
`timescale 1ns/1ps
module hsbus_link_tb_top;
  localparam int IDLE = 16;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, pwr2_ok = 1'b0;
  logic bsda_drv = 1'b0, bscl_drv = 1'b0, csda_drv = 1'b0, cscl_drv = 1'b0;
  logic precharge, connect, accel;
  logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;
  logic bp_sda_w, bp_scl_w, cd_sda_w, cd_scl_w;

  // wired-AND buses: any driver or the block pulls the line low
  assign bp_sda_w = !(bsda_drv | bp_sda_pd);
  assign bp_scl_w = !(bscl_drv | bp_scl_pd);
  assign cd_sda_w = !(csda_drv | cd_sda_pd);
  assign cd_scl_w = !(cscl_drv | cd_scl_pd);

  always #2.5 clk = ~clk;

  hsbus_link #(.IDLE_CYCLES(IDLE), .RELEASE_HOLD(HOLD), .NEED_SECOND_SUPPLY(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .pwr2_ok_i(pwr2_ok),
    .bp_sda_i(bp_sda_w), .bp_scl_i(bp_scl_w), .cd_sda_i(cd_sda_w), .cd_scl_i(cd_scl_w),
    .precharge_o(precharge), .connect_o(connect), .accel_en_o(accel),
    .bp_sda_pd_o(bp_sda_pd), .bp_scl_pd_o(bp_scl_pd),
    .cd_sda_pd_o(cd_sda_pd), .cd_scl_pd_o(cd_scl_pd)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: mode 0 lockout, 1 waiting, 2 joined
  // per line owner: 0 nobody, 1 backplane, 2 card
  int m_mode, m_cnt, m_armed;
  int m_own[2], m_last[2], m_hold[2];
  bit m_psda, m_pscl;
  bit q_bsda[$], q_bscl[$], q_csda[$], q_cscl[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_armed = 0;
      m_psda = 1; m_pscl = 1;
      for (int i = 0; i < 2; i++) begin m_own[i] = 0; m_last[i] = 0; m_hold[i] = 0; end
      q_bsda = '{1'b1, 1'b1}; q_bscl = '{1'b1, 1'b1};
      q_csda = '{1'b1, 1'b1}; q_cscl = '{1'b1, 1'b1};
    end else begin
      bit sb[2];
      bit sc[2];
      bit supply, stop, idle, joined, ev, bl, cl;
      int nh;
      sb[0] = q_bsda.pop_front(); q_bsda.push_back(bp_sda_w);
      sb[1] = q_bscl.pop_front(); q_bscl.push_back(bp_scl_w);
      sc[0] = q_csda.pop_front(); q_csda.push_back(cd_sda_w);
      sc[1] = q_cscl.pop_front(); q_cscl.push_back(cd_scl_w);
      supply = pwr_ok && pwr2_ok;
      stop   = sb[1] && m_pscl && sb[0] && !m_psda;
      idle   = (m_cnt == IDLE);
      joined = (m_mode == 2);
      for (int i = 0; i < 2; i++) begin
        bl = sb[i]; cl = sc[i];
        nh = (m_hold[i] > 0) ? m_hold[i] - 1 : 0;
        if (!joined) begin
          m_own[i] = 0; m_hold[i] = 0;
        end else if (m_own[i] == 0) begin
          if (!bl && !(m_hold[i] > 0 && m_last[i] == 2)) begin m_own[i] = 1; m_last[i] = 1; end
          else if (!cl && !(m_hold[i] > 0 && m_last[i] == 1)) begin m_own[i] = 2; m_last[i] = 2; end
          m_hold[i] = nh;
        end else if (m_own[i] == 1) begin
          if (bl) begin m_own[i] = 0; m_hold[i] = HOLD; end else m_hold[i] = nh;
        end else begin
          if (cl) begin m_own[i] = 0; m_hold[i] = HOLD; end else m_hold[i] = nh;
        end
      end
      ev = m_armed || stop || idle;
      if (m_mode == 0) begin
        m_armed = 0; m_cnt = 0;
        if (supply) m_mode = 1;
      end else if (m_mode == 1) begin
        if (!supply) begin m_mode = 0; m_armed = 0; m_cnt = 0; end
        else if (ev && sc[0] && sc[1]) begin m_mode = 2; m_armed = 0; m_cnt = 0; end
        else begin
          m_armed = ev;
          m_cnt = (sb[0] && sb[1]) ? ((m_cnt < IDLE) ? m_cnt + 1 : IDLE) : 0;
        end
      end else begin
        if (!supply) m_mode = 0;
      end
      m_psda = sb[0]; m_pscl = sb[1];
    end
  end

  // every-cycle comparison of all outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int act, exp;
      bit j;
      j   = (m_mode == 2);
      act = {precharge, connect, accel, bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd};
      exp = {m_mode == 0, j, j, j && m_own[0] == 2, j && m_own[1] == 2,
             j && m_own[0] == 1, j && m_own[1] == 1};
      if (act[6:4] != exp[6:4]) chk("R6 model", act, exp);
      else chk("R9 model", act, exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    wrap_up();
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 outputs", {precharge, connect, accel, bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd}, 7'b1000000);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 after release", {precharge, connect}, 2'b10);

    // R2 primary supply low, line activity ignored
    pwr2_ok = 1'b1;
    for (int k = 0; k < 10; k++) begin
      bsda_drv = k[1];
      csda_drv = !k[1];
      cyc(1);
      chk("R2 lockout", {precharge, connect, cd_sda_pd, bp_sda_pd}, 4'b1000);
    end
    bsda_drv = 1'b0; csda_drv = 1'b0;

    // R3 second supply also required
    pwr2_ok = 1'b0; pwr_ok = 1'b1;
    cyc(20);
    chk("R3 second supply low", {precharge, connect}, 2'b10);
    bsda_drv = 1'b1; cscl_drv = 1'b1;   // backplane busy, card SCL held
    pwr2_ok = 1'b1;
    cyc(2);
    chk("R3 lockout left", {precharge, connect}, 2'b00);

    // R4 busy backplane: clock toggles with SDA low, no STOP
    for (int k = 0; k < 4; k++) begin
      bscl_drv = 1'b1; cyc(3);
      bscl_drv = 1'b0; cyc(3);
    end
    chk("R4 no stop yet", connect, 0);
    bsda_drv = 1'b0;                    // STOP: SDA rises with SCL high
    cyc(5);
    chk("R4 card SCL low blocks", connect, 0);
    cscl_drv = 1'b0;
    cyc(5);
    chk("R4 connected after stop", connect, 1);
    chk("R6 accel with connect", {connect, accel, precharge}, 3'b110);

    // R7 backplane low mirrored to card
    bsda_drv = 1'b1;
    cyc(4);
    chk("R7 card pull", {cd_sda_pd, cd_sda_w, bp_sda_pd}, 3'b100);
    bsda_drv = 1'b0;
    cyc(10);
    chk("R9 release no latch", {bp_sda_w, cd_sda_w, bp_sda_pd, cd_sda_pd}, 4'b1100);

    // R8 and R10 card SCL low mirrored to backplane
    cscl_drv = 1'b1;
    cyc(4);
    chk("R8 R10 backplane pull", {bp_scl_pd, bp_scl_w}, 2'b10);
    cscl_drv = 1'b0;
    cyc(10);
    chk("R10 scl released", {bp_scl_w, cd_scl_w, bp_scl_pd, cd_scl_pd}, 4'b1100);

    // R9 overlapping drivers: line stays low until all release
    bsda_drv = 1'b1;
    cyc(4);
    csda_drv = 1'b1;
    cyc(3);
    bsda_drv = 1'b0;
    cyc(12);
    chk("R9 card driver holds line", {bp_sda_w, cd_sda_w}, 2'b00);
    csda_drv = 1'b0;
    cyc(12);
    chk("R9 all released", {bp_sda_w, cd_sda_w, bp_sda_pd, cd_sda_pd}, 4'b1100);

    // R12 simultaneous lows: backplane is originator
    bsda_drv = 1'b1; csda_drv = 1'b1;
    cyc(4);
    chk("R12 priority", {cd_sda_pd, bp_sda_pd}, 2'b10);
    bsda_drv = 1'b0; csda_drv = 1'b0;
    cyc(12);
    chk("R12 released", {bp_sda_w, cd_sda_w}, 2'b11);

    // R11 supply drop while mirroring
    bscl_drv = 1'b1;
    cyc(4);
    chk("R11 mirroring before drop", cd_scl_pd, 1);
    pwr_ok = 1'b0;
    cyc(1);
    chk("R11 isolated", {precharge, connect, accel, cd_scl_pd, bp_scl_pd}, 5'b10000);
    bscl_drv = 1'b0;
    cyc(4);

    // R5 idle window arms the connection
    pwr_ok = 1'b1;
    cyc(10);
    chk("R5 idle not reached", connect, 0);
    cyc(15);
    chk("R5 idle connected", {connect, accel}, 2'b11);

    cyc(2);
    wrap_up();
  end
endmodule